// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block resolves the control-transfer instructions of a 64-bit register-based virtual machine. Each accepted instruction supplies an 8-bit opcode, the current program counter (counted in 64-bit instruction slots), the two register operands, a 32-bit immediate and a signed 16-bit slot offset. One clock later the block presents the next program counter together with a taken flag, a call pulse carrying the call number, an exit pulse and an illegal-instruction flag.

The low three opcode bits pick the comparison width: class 5 compares the full 64-bit values and class 6 compares only the low 32 bits. Bit 3 picks the second operand: the source register, or the sign-extended immediate. The top nibble names the relation or action. Equality, inequality, a bit test and the unsigned and signed orderings are shared by both classes. The unconditional jump and the exit exist only in the 64-bit class. The call target lookup, the stack and instruction fetch belong to neighbouring blocks.

Top module: `bcu_branch_unit`

## Requirements
- R1: While `rst_n` is low, and until the first accepted instruction, `out_valid`, `taken`, `call_req`, `exit_req` and `illegal` are 0.
- R2: An instruction accepted with `in_valid` high at a rising edge produces its result with `out_valid` high after the next rising edge. A cycle without `in_valid` gives `out_valid` low and all action flags low, and results keep their input order.
- R3: Opcode bits [2:0] = 5 compare the whole 64-bit operands. Bits [2:0] = 6 compare bits [31:0] only, with bit 31 as the sign.
- R4: Top nibble 1 is taken when the operands are equal, 5 when they differ, and 4 when their bitwise AND is nonzero.
- R5: Top nibbles 2, 3, 0xA and 0xB are unsigned greater, greater-or-equal, less and less-or-equal.
- R6: Top nibbles 6, 7, 0xC and 0xD are signed greater, greater-or-equal, less and less-or-equal, in two's complement.
- R7: Opcode bit 3 = 1 selects `src_val` as the second operand. Bit 3 = 0 selects `imm` sign-extended to 64 bits.
- R8: A taken transfer gives `next_pc` = `pc` + 1 + sign-extended `off`. A not-taken condition gives `pc` + 1. Both wrap modulo 2^PC_W.
- R9: Top nibble 0 in class 5 is always taken.
- R10: Top nibble 9 in class 5 raises `exit_req` with `next_pc` = `pc` and `taken` = 0.
- R11: Top nibble 8 in either class raises `call_req` with `call_id` = `imm`, `next_pc` = `pc` + 1 and `taken` = 0. `call_id` is 0 for every other result.
- R12: Top nibble 0 or 9 in class 6, top nibble 0xE or 0xF, or any class other than 5 and 6 raises `illegal` and gives `next_pc` = `pc`.
- R13: At most one of `taken`, `call_req`, `exit_req` and `illegal` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Opcode: [7:4] action, [3] operand select, [2:0] class |
| pc | input | PC_W | Current slot index |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate / call number |
| off | input | 16 | Signed slot offset |
| out_valid | output | 1 | Result present |
| next_pc | output | PC_W | Next slot index |
| taken | output | 1 | Transfer to the offset target |
| call_req | output | 1 | Call pulse |
| call_id | output | 32 | Call number while `call_req` is high, else 0 |
| exit_req | output | 1 | Program exit pulse |
| illegal | output | 1 | Illegal jump-class opcode |

## Verification
Each relation is driven with operand pairs on both sides of its boundary: equal, one apart, and sign-opposite values. This separates signed from unsigned decoding and the strict relations from the non-strict ones. Operands that match in their low 32 bits but differ above are run through both classes, and so are values whose bit 31 and bit 63 disagree, which shows that the width and the sign bit follow the class. A negative immediate in an unsigned compare shows that sign extension happens before the compare. Negative offsets and offsets that wrap past zero check the target arithmetic, and the action codes and illegal codes are run in both classes.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  // Action codes carried in opcode[7:4]
  typedef enum logic [3:0] {
    ACT_ALWAYS = 4'h0,
    ACT_EQ     = 4'h1,
    ACT_UGT    = 4'h2,
    ACT_UGE    = 4'h3,
    ACT_ANYSET = 4'h4,
    ACT_NE     = 4'h5,
    ACT_SGT    = 4'h6,
    ACT_SGE    = 4'h7,
    ACT_CALL   = 4'h8,
    ACT_EXIT   = 4'h9,
    ACT_ULT    = 4'hA,
    ACT_ULE    = 4'hB,
    ACT_SLT    = 4'hC,
    ACT_SLE    = 4'hD,
    ACT_RSV_E  = 4'hE,
    ACT_RSV_F  = 4'hF
  } act_e;

  // What the decoded instruction asks for
  typedef enum logic [2:0] {
    K_COND    = 3'd0,
    K_ALWAYS  = 3'd1,
    K_CALL    = 3'd2,
    K_EXIT    = 3'd3,
    K_ILLEGAL = 3'd4
  } kind_e;

  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;

  // Four primitive relations from which every condition is derived
  typedef struct packed {
    logic eq;
    logic ugt;
    logic sgt;
    logic anyset;
  } rel_t;

  function automatic logic cond_hit(input act_e act, input rel_t r);
    logic h;
    case (act)
      ACT_EQ:     h = r.eq;
      ACT_NE:     h = !r.eq;
      ACT_ANYSET: h = r.anyset;
      ACT_UGT:    h = r.ugt;
      ACT_UGE:    h = r.ugt | r.eq;
      ACT_ULT:    h = !r.ugt & !r.eq;
      ACT_ULE:    h = !r.ugt;
      ACT_SGT:    h = r.sgt;
      ACT_SGE:    h = r.sgt | r.eq;
      ACT_SLT:    h = !r.sgt & !r.eq;
      ACT_SLE:    h = !r.sgt;
      default:    h = 1'b0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
  import bcu_pkg::*;
(
  input  logic [7:0] opcode,
  output act_e       act,
  output kind_e      kind,
  output logic       narrow,
  output logic       use_reg
);

  logic is_wide;
  logic is_narrow;

  assign is_wide   = (opcode[2:0] == CLS_WIDE);
  assign is_narrow = (opcode[2:0] == CLS_NARROW);
  assign act       = act_e'(opcode[7:4]);
  assign narrow    = is_narrow;
  assign use_reg   = opcode[3];

  always_comb begin
    kind = K_ILLEGAL;
    if (is_wide || is_narrow) begin
      case (act)
        ACT_ALWAYS: kind = is_wide ? K_ALWAYS : K_ILLEGAL;
        ACT_EXIT:   kind = is_wide ? K_EXIT : K_ILLEGAL;
        ACT_CALL:   kind = K_CALL;
        ACT_RSV_E,
        ACT_RSV_F:  kind = K_ILLEGAL;
        default:    kind = K_COND;
      endcase
    end
  end

endmodule

// File: rtl/bcu_compare.sv
module bcu_compare
  import bcu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  logic            narrow,
  output rel_t            rel
);

  localparam int LANES = 2;

  logic [LANES-1:0] eq_l;
  logic [LANES-1:0] ugt_l;
  logic [LANES-1:0] sgt_l;
  logic [LANES-1:0] any_l;

  // Lane 0 spans the full word, lane 1 the low half
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int W = XLEN >> g;
    logic [W-1:0] la;
    logic [W-1:0] lb;
    assign la       = lhs[W-1:0];
    assign lb       = rhs[W-1:0];
    assign eq_l[g]  = (la == lb);
    assign ugt_l[g] = (la > lb);
    assign sgt_l[g] = ($signed(la) > $signed(lb));
    assign any_l[g] = |(la & lb);
  end

  always_comb begin
    if (narrow) begin
      rel.eq = eq_l[1]; rel.ugt = ugt_l[1]; rel.sgt = sgt_l[1]; rel.anyset = any_l[1];
    end else begin
      rel.eq = eq_l[0]; rel.ugt = ugt_l[0]; rel.sgt = sgt_l[0]; rel.anyset = any_l[0];
    end
  end

endmodule

// File: rtl/bcu_pc_next.sv
module bcu_pc_next
  import bcu_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  kind_e            kind,
  input  logic             hit,
  output logic [PC_W-1:0]  next_pc,
  output logic             taken
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] tgt_pc;
  logic [PC_W-1:0] off_x;

  assign off_x  = {{EXT_W{off[OFF_W-1]}}, off};
  assign seq_pc = pc + PC_W'(1);
  assign tgt_pc = seq_pc + off_x;

  always_comb begin
    case (kind)
      K_COND:   taken = hit;
      K_ALWAYS: taken = 1'b1;
      default:  taken = 1'b0;
    endcase
    if (taken)                                 next_pc = tgt_pc;
    else if (kind == K_EXIT || kind == K_ILLEGAL) next_pc = pc;
    else                                       next_pc = seq_pc;
  end

endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
  import bcu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int PC_W  = 32,
  parameter int IMM_W = 32,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       opcode,
  input  logic [PC_W-1:0]  pc,
  input  logic [XLEN-1:0]  dst_val,
  input  logic [XLEN-1:0]  src_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [OFF_W-1:0] off,
  output logic             out_valid,
  output logic [PC_W-1:0]  next_pc,
  output logic             taken,
  output logic             call_req,
  output logic [IMM_W-1:0] call_id,
  output logic             exit_req,
  output logic             illegal
);

  localparam int IMM_EXT = XLEN - IMM_W;

  // Named internal events
  act_e            dec_act;
  kind_e           dec_kind;
  logic            dec_narrow;
  logic            dec_use_reg;
  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] rhs_val;
  rel_t            cmp_rel;
  logic            cmp_hit;
  logic [PC_W-1:0] nxt_pc;
  logic            nxt_taken;

  bcu_decode u_dec (
    .opcode  (opcode),
    .act     (dec_act),
    .kind    (dec_kind),
    .narrow  (dec_narrow),
    .use_reg (dec_use_reg)
  );

  assign imm_x   = {{IMM_EXT{imm[IMM_W-1]}}, imm};
  assign rhs_val = dec_use_reg ? src_val : imm_x;

  bcu_compare #(.XLEN(XLEN)) u_cmp (
    .lhs    (dst_val),
    .rhs    (rhs_val),
    .narrow (dec_narrow),
    .rel    (cmp_rel)
  );

  assign cmp_hit = cond_hit(dec_act, cmp_rel);

  bcu_pc_next #(.PC_W(PC_W), .OFF_W(OFF_W)) u_nxt (
    .pc      (pc),
    .off     (off),
    .kind    (dec_kind),
    .hit     (cmp_hit),
    .next_pc (nxt_pc),
    .taken   (nxt_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      call_req  <= 1'b0;
      call_id   <= '0;
      exit_req  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_pc  <= nxt_pc;
        taken    <= nxt_taken;
        call_req <= (dec_kind == K_CALL);
        call_id  <= (dec_kind == K_CALL) ? imm : '0;
        exit_req <= (dec_kind == K_EXIT);
        illegal  <= (dec_kind == K_ILLEGAL);
      end else begin
        taken    <= 1'b0;
        call_req <= 1'b0;
        call_id  <= '0;
        exit_req <= 1'b0;
        illegal  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bcu_branch_unit_chk.sv
module bcu_branch_unit_chk
  import bcu_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IMM_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PC_W-1:0]  pc,
  input logic [IMM_W-1:0] imm,
  input kind_e            dec_kind,
  input logic             cmp_hit,
  input logic             out_valid,
  input logic [PC_W-1:0]  next_pc,
  input logic             taken,
  input logic             call_req,
  input logic [IMM_W-1:0] call_id,
  input logic             exit_req,
  input logic             illegal
);

  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  assert_flags_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, call_req, exit_req, illegal}));

  assert_flags_need_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken | call_req | exit_req | illegal) |-> out_valid);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_exit_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> (next_pc == $past(pc)));

  assert_illegal_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (next_pc == $past(pc)));

  assert_call_id_R11: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_id == $past(imm) && next_pc == $past(pc) + ONE));

  assert_fallthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !taken && !call_req && !exit_req && !illegal) |-> (next_pc == $past(pc) + ONE));

  assert_cond_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_kind == K_COND) |=> (taken == $past(cmp_hit)));

endmodule

bind bcu_branch_unit bcu_branch_unit_chk #(.PC_W(PC_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .pc        (pc),
  .imm       (imm),
  .dec_kind  (dec_kind),
  .cmp_hit   (cmp_hit),
  .out_valid (out_valid),
  .next_pc   (next_pc),
  .taken     (taken),
  .call_req  (call_req),
  .call_id   (call_id),
  .exit_req  (exit_req),
  .illegal   (illegal)
);

// File: tb/bcu_branch_unit_tb.sv
module bcu_branch_unit_tb;

  localparam int PC_W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [31:0] pc = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [31:0] imm = '0;
  logic [15:0] off = '0;
  logic        out_valid;
  logic [31:0] next_pc;
  logic        taken;
  logic        call_req;
  logic [31:0] call_id;
  logic        exit_req;
  logic        illegal;

  always #2 clk = ~clk;  // 250 MHz

  bcu_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .pc(pc),
    .dst_val(dst_val), .src_val(src_val), .imm(imm), .off(off),
    .out_valid(out_valid), .next_pc(next_pc), .taken(taken), .call_req(call_req),
    .call_id(call_id), .exit_req(exit_req), .illegal(illegal)
  );

  typedef struct {
    logic [31:0] npc;
    logic        tk;
    logic        cl;
    logic [31:0] id;
    logic        ex;
    logic        il;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  // Independent reference: walks the opcode fields and compares with integer types
  function automatic exp_t model(input logic [7:0] op, input logic [31:0] p,
                                 input logic [63:0] d, input logic [63:0] s,
                                 input logic [31:0] im, input logic [15:0] of,
                                 input string tag);
    exp_t e;
    logic [63:0] b;
    longint unsigned ua, ub;
    longint sa, sb;
    bit cond;
    bit wide;
    b = op[3] ? s : {{32{im[31]}}, im};
    wide = (op[2:0] == 3'd5);
    if (wide) begin
      ua = d; ub = b; sa = $signed(d); sb = $signed(b);
    end else begin
      ua = {32'd0, d[31:0]}; ub = {32'd0, b[31:0]};
      sa = longint'($signed(d[31:0])); sb = longint'($signed(b[31:0]));
    end
    e.npc = p + 32'd1; e.tk = 0; e.cl = 0; e.id = 0; e.ex = 0; e.il = 0; e.tag = tag;
    cond = 0;
    if (op[2:0] != 3'd5 && op[2:0] != 3'd6) begin
      e.il = 1; e.npc = p;
    end else begin
      case (op[7:4])
        4'h0: if (wide) cond = 1; else begin e.il = 1; e.npc = p; end
        4'h9: begin e.npc = p; if (wide) e.ex = 1; else e.il = 1; end
        4'h8: begin e.cl = 1; e.id = im; end
        4'hE, 4'hF: begin e.il = 1; e.npc = p; end
        4'h1: cond = (ua == ub);
        4'h5: cond = (ua != ub);
        4'h4: cond = ((ua & ub) != 0);
        4'h2: cond = (ua > ub);
        4'h3: cond = (ua >= ub);
        4'hA: cond = (ua < ub);
        4'hB: cond = (ua <= ub);
        4'h6: cond = (sa > sb);
        4'h7: cond = (sa >= sb);
        4'hC: cond = (sa < sb);
        default: cond = (sa <= sb);
      endcase
    end
    if (cond) begin
      e.tk = 1;
      e.npc = p + 32'd1 + {{16{of[15]}}, of};
    end
    return e;
  endfunction

  task automatic send(input logic [7:0] op, input logic [31:0] p, input logic [63:0] d,
                      input logic [63:0] s, input logic [31:0] im, input logic [15:0] of,
                      input string tag);
    @(negedge clk);
    opcode = op; pc = p; dst_val = d; src_val = s; imm = im; off = of; in_valid = 1'b1;
    exp_q.push_back(model(op, p, d, s, im, of, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input string act, input string expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, expv);
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected result", "out_valid=1", "no pending item");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(next_pc == e.npc && taken == e.tk && call_req == e.cl && call_id == e.id
                && exit_req == e.ex && illegal == e.il, e.tag,
                $sformatf("npc=%0h tk=%0b cl=%0b id=%0h ex=%0b il=%0b",
                          next_pc, taken, call_req, call_id, exit_req, illegal),
                $sformatf("npc=%0h tk=%0b cl=%0b id=%0h ex=%0b il=%0b",
                          e.npc, e.tk, e.cl, e.id, e.ex, e.il));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !taken && !call_req && !exit_req && !illegal, "R1 reset state",
          $sformatf("%0b%0b%0b%0b%0b", out_valid, taken, call_req, exit_req, illegal), "00000");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(!out_valid && !taken, "R1 after release", $sformatf("%0b%0b", out_valid, taken), "00");

    // R4 equality family, R3 width
    send(8'h1D, 32'd10, 64'h1234, 64'h1234, 0, 16'd5, "R4 eq64 equal");
    send(8'h1D, 32'd10, 64'h1_0000_0005, 64'h5, 0, 16'd5, "R3 eq64 upper differ");
    send(8'h1E, 32'd10, 64'h1_0000_0005, 64'h5, 0, 16'd5, "R3 eq32 upper ignored");
    send(8'h5D, 32'd20, 64'h7, 64'h8, 0, 16'd2, "R4 ne taken");
    send(8'h45, 32'd20, 64'h30, 0, 32'h10, 16'd1, "R4 anyset hit");
    send(8'h45, 32'd20, 64'h20, 0, 32'h10, 16'd1, "R4 anyset miss");
    // R5 unsigned, R7 immediate sign extension
    send(8'h25, 32'd30, 64'h5, 0, 32'hFFFF_FFFF, 16'd4, "R7 ugt neg imm sext");
    send(8'h2D, 32'd30, 64'h5, 64'h3, 0, 16'd4, "R5 ugt reg");
    send(8'h3D, 32'd30, 64'h9, 64'h9, 0, 16'd4, "R5 uge equal");
    send(8'hAD, 32'd30, 64'h1, 64'h2, 0, 16'd4, "R5 ult");
    send(8'hBD, 32'd30, 64'h3, 64'h2, 0, 16'd4, "R5 ule false");
    send(8'hBE, 32'd30, 64'hFFFF_0000_0000_0002, 64'h2, 0, 16'd4, "R3 ule32 equal low");
    // R6 signed, both widths
    send(8'h65, 32'd40, 64'h0000_0000_8000_0000, 0, 32'd1, 16'd8, "R6 sgt64 positive");
    send(8'h66, 32'd40, 64'h0000_0000_8000_0000, 0, 32'd1, 16'd8, "R3 sgt32 bit31 sign");
    send(8'h75, 32'd40, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'hFFFF_FFFF, 16'd8, "R6 sge equal neg");
    send(8'hC5, 32'd40, 64'hFFFF_FFFF_FFFF_FFFB, 0, 32'd3, 16'd8, "R6 slt neg");
    send(8'hD6, 32'd40, 64'h0000_0000_FFFF_FFFF, 0, 32'd0, 16'd8, "R6 sle32 neg");
    send(8'hDD, 32'd40, 64'h0000_0000_FFFF_FFFF, 64'h0, 0, 16'd8, "R6 sle64 false");
    send(8'h6D, 32'd40, 64'h1, 64'h8000_0000_0000_0000, 0, 16'd8, "R6 sgt min reg");
    // R8 offset arithmetic
    send(8'h1D, 32'd100, 64'h1, 64'h1, 0, 16'hFFFD, "R8 negative offset");
    send(8'h1D, 32'd0, 64'h1, 64'h1, 0, 16'hFFFB, "R8 wrap below zero");
    idle();
    idle();
    #1;
    check(!out_valid && !taken, "R2 idle gap", $sformatf("%0b%0b", out_valid, taken), "00");
    // R9..R12 actions
    send(8'h05, 32'd50, 0, 0, 0, 16'd7, "R9 always wide");
    send(8'h06, 32'd50, 0, 0, 0, 16'd7, "R12 always narrow");
    send(8'h95, 32'd60, 0, 0, 0, 16'd7, "R10 exit wide");
    send(8'h96, 32'd60, 0, 0, 0, 16'd7, "R12 exit narrow");
    send(8'h85, 32'd70, 0, 0, 32'h1234, 16'd7, "R11 call wide");
    send(8'h86, 32'd71, 0, 0, 32'hABCD, 16'd7, "R11 call narrow");
    send(8'hE5, 32'd80, 0, 0, 0, 16'd7, "R12 code E");
    send(8'hFD, 32'd80, 0, 0, 0, 16'd7, "R12 code F");
    send(8'h17, 32'd80, 1, 1, 0, 16'd7, "R12 other class");
    send(8'h1D, 32'd90, 3, 4, 0, 16'd7, "R13 plain fallthrough");
    idle();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all results delivered", $sformatf("%0d", exp_q.size()), "0");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule